// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block drives one DMA channel. It moves 32-bit words between a memory port and a device port. Software sets up three registers through a small write port: a start address, a block-control word and a channel-control word. The sequencer then copies words one at a time. It reads each word from the source side, holds it in a single data register, and writes it to the destination side. After every word it moves the address up or down by four. The address always stays word aligned inside a 2 MB window.

Two sync modes move data. In manual mode, one run of a programmed length starts from a software trigger. In block-request mode, the device's request line starts each block, and the channel stays armed between blocks until the last one has moved. An optional chopping feature splits a run into bursts with a fixed number of words. Each burst is followed by a quiet gap of a fixed number of clock cycles, during which the memory bus is free for the processor. When the transfer finishes, the channel clears its own run bits and sends a one-cycle completion pulse to the interrupt logic.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, all three registers read as zero, `busy` and `done` are low, and neither port has a valid request.
- R2: Channel control (register select 2) takes only the bits in mask 0x71770703 on a write, and the other bits stay zero. Fields: bit 0 direction, bit 1 reverse step, bit 8 chop enable, bits 10:9 sync mode, bits 18:16 burst exponent, bits 22:20 gap exponent, bit 24 enable (read as `busy`), bit 28 trigger. Register select 0 is the start address and select 1 is block control.
- R3: Sync mode 0 (manual) starts only when the enable and trigger bits are both set. It moves the number of words in block-control bits 15:0, and a value of 0 means 65536 words.
- R4: With direction bit 1, each word is read from memory and then written to the device. With direction bit 0, each word is read from the device and then written to memory. Word order is kept, and only one port is active at a time.
- R5: The first address is the start address ANDed with 0x001FFFFC. Each later address is the previous one plus 4, or minus 4 when bit 1 is set, and it is masked again, so it wraps inside the 2 MB window.
- R6: Sync mode 1 (block request) moves blocks of block-control bits 15:0 words. The number of blocks is in bits 31:16, and 0 in either field means 65536. Each block starts only while the device request input is high, and between blocks the channel stays enabled with both ports idle.
- R7: When the last word finishes, the enable and trigger bits clear and `done` is high for exactly one cycle. In block-request mode, the start-address register then holds the address that follows the last word. In manual mode, it keeps its programmed value.
- R8: With chopping enabled and words still left, every 2^(burst exponent) words are followed by 2^(gap exponent) cycles in which neither port is requested.
- R9: Sync modes 2 and 3 never start a transfer. Neither port is requested, and the enable bit stays as written.
- R10: A valid request on either port holds its address, write flag and data until ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for write and read (0 address, 1 block control, 2 channel control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| dev_req | input | 1 | Device request line for block-request mode |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, taken in the handshake cycle |
| mem_ready | input | 1 | Memory accepts the access |
| dev_valid | output | 1 | Device access request |
| dev_we | output | 1 | Device write (1) or read (0) |
| dev_wdata | output | 32 | Data to the device |
| dev_rdata | input | 32 | Data from the device, taken in the handshake cycle |
| dev_ready | input | 1 | Device accepts the access |
| busy | output | 1 | Channel enable bit |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle the properties that hold at any instant:
- the two ports are never requested together;
- addresses stay aligned and inside the window;
- requests hold their address, write flag and data while stalled;
- no request appears during a chopping gap;
- the completion pulse lasts one cycle and comes with the enable bit cleared;
- modes 2 and 3 never leave idle.

Only the bench scenarios can show the end-to-end behaviour: the exact sequence of addresses and data, reverse stepping and wrap-around, the zero-means-65536 count, the waits between blocks on the request line, the length of the chopping gaps, and the write-back of the final address.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam logic [31:0] CTL_WMASK = 32'h7177_0703;
    localparam logic [31:0] WIN_MASK  = 32'h001F_FFFC;

    localparam int B_DIR  = 0;
    localparam int B_REV  = 1;
    localparam int B_CHOP = 8;
    localparam int B_MODE = 9;
    localparam int B_BEXP = 16;
    localparam int B_GEXP = 20;
    localparam int B_EN   = 24;
    localparam int B_TRIG = 28;
    localparam int EXP_W  = 3;

    typedef enum logic [1:0] {
        SYNC_MANUAL = 2'd0,
        SYNC_BLOCK  = 2'd1,
        SYNC_LIST   = 2'd2,
        SYNC_RSVD   = 2'd3
    } sync_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SRC,
        ST_DST,
        ST_WAIT
    } seq_st_e;

    function automatic logic [16:0] expand_cnt(input logic [15:0] f);
        return (f == 16'd0) ? 17'h1_0000 : {1'b0, f};
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int          AW   = 32,
    parameter logic [AW-1:0] MASK = AW'(32'h001F_FFFC)
) (
    input  logic [AW-1:0] cur_i,
    input  logic          rev_i,
    output logic [AW-1:0] nxt_o
);
    always_comb begin
        nxt_o = (rev_i ? (cur_i - AW'(4)) : (cur_i + AW'(4))) & MASK;
    end
endmodule

// File: rtl/dma_chop_timer.sv
module dma_chop_timer #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             word_i,
    input  logic             more_i,
    input  logic             en_i,
    input  logic [EXP_W-1:0] bexp_i,
    input  logic [EXP_W-1:0] gexp_i,
    output logic             pause_o
);
    localparam int CW = 1 << EXP_W;

    typedef struct packed {
        logic [CW-1:0] burst;
        logic [CW-1:0] gap;
    } chop_s;

    chop_s q, d;
    logic [CW-1:0] burst_lim, gap_len;

    always_comb begin
        burst_lim = CW'(1) << bexp_i;
        gap_len   = CW'(1) << gexp_i;
        d = q;
        if (restart_i) begin
            d.burst = '0;
            d.gap   = '0;
        end else if (word_i) begin
            if (en_i && more_i && (q.burst + CW'(1) == burst_lim)) begin
                d.burst = '0;
                d.gap   = gap_len;
            end else if (en_i) begin
                d.burst = q.burst + CW'(1);
            end
        end else if (q.gap != '0) begin
            d.gap = q.gap - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pause_o = (q.gap != '0);

    // R8: a gap only counts down, it never restarts by itself
    a_r8_gap_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (q.gap != '0 && !restart_i && !word_i) |=> (q.gap == $past(q.gap) - CW'(1)));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dev_req,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              dev_valid,
    output logic              dev_we,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              dev_ready,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        seq_st_e           st;
        logic [31:0]       ctl;
        logic [31:0]       base;
        logic [31:0]       blk;
        logic [31:0]       addr;
        logic [16:0]       words;
        logic [16:0]       blocks;
        logic [DATA_W-1:0] data;
        logic              done;
    } seq_s;

    seq_s q, d;

    sync_e       mode;
    logic        to_dev, rev, chop_en, en, trig;
    logic [31:0] addr_nxt;
    logic        pause, chop_restart, word_done, dst_hs;

    assign mode    = sync_e'(q.ctl[B_MODE +: 2]);
    assign to_dev  = q.ctl[B_DIR];
    assign rev     = q.ctl[B_REV];
    assign chop_en = q.ctl[B_CHOP];
    assign en      = q.ctl[B_EN];
    assign trig    = q.ctl[B_TRIG];

    dma_addr_step #(.AW(32), .MASK(WIN_MASK)) u_step (
        .cur_i (q.addr),
        .rev_i (rev),
        .nxt_o (addr_nxt)
    );

    dma_chop_timer #(.EXP_W(EXP_W)) u_chop (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (chop_restart),
        .word_i    (word_done),
        .more_i    (q.words != 17'd1),
        .en_i      (chop_en),
        .bexp_i    (q.ctl[B_BEXP +: EXP_W]),
        .gexp_i    (q.ctl[B_GEXP +: EXP_W]),
        .pause_o   (pause)
    );

    always_comb begin
        d            = q;
        d.done       = 1'b0;
        mem_valid    = 1'b0;
        mem_we       = 1'b0;
        dev_valid    = 1'b0;
        dev_we       = 1'b0;
        chop_restart = 1'b0;
        word_done    = 1'b0;
        dst_hs       = 1'b0;

        if (reg_we) begin
            case (reg_sel)
                2'd0:    d.base = reg_wdata;
                2'd1:    d.blk  = reg_wdata;
                2'd2:    d.ctl  = (q.ctl & ~CTL_WMASK) | (reg_wdata & CTL_WMASK);
                default: ;
            endcase
        end

        case (q.st)
            ST_IDLE: begin
                if (en && ((mode == SYNC_MANUAL && trig) || (mode == SYNC_BLOCK && dev_req))) begin
                    d.addr       = q.base & WIN_MASK;
                    d.words      = expand_cnt(q.blk[15:0]);
                    d.blocks     = expand_cnt(q.blk[31:16]);
                    chop_restart = 1'b1;
                    d.st         = ST_SRC;
                end
            end
            ST_SRC: begin
                if (!pause) begin
                    if (to_dev) begin
                        mem_valid = 1'b1;
                        if (mem_ready) begin
                            d.data = mem_rdata;
                            d.st   = ST_DST;
                        end
                    end else begin
                        dev_valid = 1'b1;
                        if (dev_ready) begin
                            d.data = dev_rdata;
                            d.st   = ST_DST;
                        end
                    end
                end
            end
            ST_DST: begin
                if (to_dev) begin
                    dev_valid = 1'b1;
                    dev_we    = 1'b1;
                    dst_hs    = dev_ready;
                end else begin
                    mem_valid = 1'b1;
                    mem_we    = 1'b1;
                    dst_hs    = mem_ready;
                end
                if (dst_hs) begin
                    word_done = 1'b1;
                    d.addr    = addr_nxt;
                    d.words   = q.words - 17'd1;
                    if (q.words != 17'd1) begin
                        d.st = ST_SRC;
                    end else if (mode == SYNC_BLOCK && q.blocks != 17'd1) begin
                        d.blocks = q.blocks - 17'd1;
                        d.st     = ST_WAIT;
                    end else begin
                        d.ctl[B_EN]   = 1'b0;
                        d.ctl[B_TRIG] = 1'b0;
                        d.done        = 1'b1;
                        d.st          = ST_IDLE;
                        if (mode == SYNC_BLOCK) d.base = addr_nxt;
                    end
                end
            end
            ST_WAIT: begin
                if (dev_req) begin
                    d.words      = expand_cnt(q.blk[15:0]);
                    chop_restart = 1'b1;
                    d.st         = ST_SRC;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_sel)
            2'd0:    reg_rdata = q.base;
            2'd1:    reg_rdata = q.blk;
            2'd2:    reg_rdata = q.ctl;
            default: reg_rdata = '0;
        endcase
    end

    assign mem_addr  = q.addr;
    assign mem_wdata = q.data;
    assign dev_wdata = q.data;
    assign busy      = en;
    assign done      = q.done;

    // R4: one side of the copy at a time
    a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && dev_valid));
    // R5: every memory address is aligned and inside the window
    a_r5_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((mem_addr & ~WIN_MASK) == 32'd0));
    // R10: stalled requests hold steady
    a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    a_r10_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_we) && $stable(dev_wdata)));
    // R7: completion is a single pulse and leaves the channel disabled
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8: nothing is requested during a chopping gap
    a_r8_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && q.st == ST_SRC) |-> (!mem_valid && !dev_valid));
    // R9: list and reserved modes stay idle
    a_r9_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && q.ctl[B_MODE + 1]) |=> (q.st == ST_IDLE));
    // R3: an active run never has an empty word count
    a_r3_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SRC || q.st == ST_DST) |-> (q.words != 17'd0));
    // R2: bits outside the write mask stay clear
    a_r2_locked_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctl & ~CTL_WMASK) == 32'd0);
endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] MASK       = 32'h001F_FFFC;
    localparam logic [31:0] MKEY       = 32'h5A00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_req = 1'b0;
    logic        mem_valid, mem_we, dev_valid, dev_we, busy, done;
    logic [31:0] mem_addr, mem_wdata, dev_wdata;
    logic [31:0] mem_rdata, dev_rdata;
    logic        mem_ready = 1'b1;
    logic        dev_ready = 1'b1;

    int checks = 0;
    int fails = 0;
    int act_cnt = 0;
    int done_cnt = 0;
    int cyc = 0;
    logic [15:0] dev_seq = '0;
    logic [15:0] exp_seq = '0;
    logic        dev_rd_seen = 1'b0;
    logic        stall = 1'b0;
    logic        rec_times = 1'b0;
    logic [7:0]  lfsr = 8'h5D;
    logic [63:0] q_mem[$];
    logic [63:0] q_dev[$];
    int          dev_times[$];

    assign mem_rdata = mem_addr ^ MKEY;
    assign dev_rdata = {16'hD000, dev_seq};

    dma_chan_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .dev_valid(dev_valid), .dev_we(dev_we), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .dev_ready(dev_ready), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ready and device-data driver, just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (dev_rd_seen) begin
                dev_seq = dev_seq + 16'd1;
                dev_rd_seen = 1'b0;
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_ready = stall ? (lfsr[0] | lfsr[2]) : 1'b1;
            dev_ready = stall ? (lfsr[1] | lfsr[4]) : 1'b1;
        end
    end

    // monitor: samples at the falling edge, pops the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (mem_valid || dev_valid) act_cnt++;
            if (done) done_cnt++;
            if (dev_valid && dev_ready && !dev_we) dev_rd_seen = 1'b1;
            if (mem_valid && mem_ready && mem_we) begin
                if (q_mem.size() == 0) chk(1'b0, "R4 unexpected memory write", {mem_addr, mem_wdata}, 64'd0);
                else begin
                    logic [63:0] e;
                    e = q_mem.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R4/R5 memory write", {mem_addr, mem_wdata}, e);
                end
            end
            if (dev_valid && dev_ready && dev_we) begin
                if (rec_times) dev_times.push_back(cyc);
                if (q_dev.size() == 0) chk(1'b0, "R4 unexpected device write", {32'd0, dev_wdata}, 64'd0);
                else begin
                    logic [63:0] e;
                    e = q_dev.pop_front();
                    chk({32'd0, dev_wdata} == e, "R4/R5 device write", {32'd0, dev_wdata}, e);
                end
            end
        end
    end

    task automatic push_run(input logic to_dev, input logic [31:0] base, input int n, input logic rev);
        logic [31:0] a;
        a = base & MASK;
        for (int i = 0; i < n; i++) begin
            if (to_dev) q_dev.push_back({32'd0, a ^ MKEY});
            else begin
                q_mem.push_back({a, 16'hD000, exp_seq});
                exp_seq = exp_seq + 16'd1;
            end
            a = (rev ? a - 32'd4 : a + 32'd4) & MASK;
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] v);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        @(posedge clk); #1;
        reg_sel = s;
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic quiet(input int n, input string tag);
        int a0;
        a0 = act_cnt;
        repeat (n) @(negedge clk);
        chk(act_cnt == a0, tag, 64'(act_cnt - a0), 64'd0);
    endtask

    task automatic wait_done(input int tgt, input string tag);
        while (done_cnt < tgt) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(done_cnt == tgt, tag, 64'(done_cnt), 64'(tgt));
        chk(q_mem.size() == 0 && q_dev.size() == 0, "R4 scoreboard drained",
            64'(q_mem.size() + q_dev.size()), 64'd0);
        chk(!busy, "R7 busy cleared", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int s = 0; s < 3; s++) begin
            rd(2'(s), v);
            chk(v == 32'd0, "R1 register reset", {32'd0, v}, 64'd0);
        end
        chk(!busy && !done && !mem_valid && !dev_valid, "R1 outputs idle",
            {60'd0, busy, done, mem_valid, dev_valid}, 64'd0);

        // R2 write mask, R9 reserved and list modes
        wr(2'd1, 32'h0000_0004);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v);
        chk(v == 32'h7177_0703, "R2 write mask", {32'd0, v}, 64'h7177_0703);
        quiet(20, "R9 reserved mode idle");
        chk(busy, "R9 enable kept in reserved mode", 64'(busy), 64'd1);
        wr(2'd2, 32'h1100_0401);
        quiet(20, "R9 list mode idle");
        wr(2'd2, 32'h0);

        // R3/R4/R5/R10 manual, memory to device, ascending, with stalls
        stall = 1'b1;
        wr(2'd0, 32'h0000_1000);
        wr(2'd1, 32'h0000_0005);
        push_run(1'b1, 32'h0000_1000, 5, 1'b0);
        wr(2'd2, 32'h1100_0001);
        wait_done(1, "R7 done pulse manual to device");
        rd(2'd2, v);
        chk(v == 32'h0000_0001, "R7 enable and trigger cleared", {32'd0, v}, 64'h1);
        rd(2'd0, v);
        chk(v == 32'h0000_1000, "R7 manual keeps start address", {32'd0, v}, 64'h1000);

        // R3 no trigger, no run; then R5 reverse with wrap, device to memory
        wr(2'd0, 32'hFF00_0006);
        wr(2'd1, 32'h0000_0004);
        wr(2'd2, 32'h0100_0002);
        quiet(15, "R3 manual waits for trigger");
        push_run(1'b0, 32'hFF00_0006, 4, 1'b1);
        wr(2'd2, 32'h1100_0002);
        wait_done(2, "R5 done pulse reverse wrap");
        rd(2'd0, v);
        chk(v == 32'hFF00_0006, "R7 manual keeps start address raw", {32'd0, v}, 64'hFF00_0006);

        // R6 block request: 2 blocks of 3 words, device to memory
        stall = 1'b0;
        wr(2'd0, 32'h0000_0100);
        wr(2'd1, 32'h0002_0003);
        wr(2'd2, 32'h0100_0200);
        quiet(10, "R6 waits for request");
        push_run(1'b0, 32'h0000_0100, 6, 1'b0);
        @(posedge clk); #1 dev_req = 1'b1;
        while (q_mem.size() > 3) @(negedge clk);
        @(posedge clk); #1 dev_req = 1'b0;
        quiet(10, "R6 idle between blocks");
        chk(busy && done_cnt == 2, "R6 still armed between blocks", {63'd0, busy}, 64'd1);
        @(posedge clk); #1 dev_req = 1'b1;
        wait_done(3, "R6 done after last block");
        dev_req = 1'b0;
        rd(2'd0, v);
        chk(v == 32'h0000_0118, "R7 block mode writes back address", {32'd0, v}, 64'h118);
        rd(2'd2, v);
        chk(v == 32'h0000_0200, "R7 block mode bits cleared", {32'd0, v}, 64'h200);

        // R8 chopping: bursts of 2 words, gaps of 4 cycles
        wr(2'd0, 32'h0000_2000);
        wr(2'd1, 32'h0000_0006);
        push_run(1'b1, 32'h0000_2000, 6, 1'b0);
        rec_times = 1'b1;
        wr(2'd2, 32'h1121_0101);
        wait_done(4, "R8 done after chopped run");
        rec_times = 1'b0;
        chk(dev_times.size() == 6, "R8 word count", 64'(dev_times.size()), 64'd6);
        if (dev_times.size() == 6) begin
            chk(dev_times[1] - dev_times[0] == 2, "R8 gap inside burst", 64'(dev_times[1] - dev_times[0]), 64'd2);
            chk(dev_times[2] - dev_times[1] == 6, "R8 gap after burst", 64'(dev_times[2] - dev_times[1]), 64'd6);
            chk(dev_times[4] - dev_times[3] == 6, "R8 second gap", 64'(dev_times[4] - dev_times[3]), 64'd6);
        end

        // R3 zero count means 65536 words
        wr(2'd0, 32'h0000_0000);
        wr(2'd1, 32'h0000_0000);
        push_run(1'b1, 32'h0000_0000, 65536, 1'b0);
        wr(2'd2, 32'h1100_0001);
        wait_done(5, "R3 zero count runs 65536 words");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule